// File: doc/BRIEF.md
# Pilot-Tone Phase-Locked Loop Core

This block is a fixed-point digital phase-locked loop. It pulls a local oscillator onto a sinusoidal pilot tone that is buried in a sampled stream. Each sample arrives with a valid strobe, as a real value or as a complex I/Q pair. The sample is mixed with the sine and cosine of the loop's own phase, and each of the two products passes through a two-pole recursive low-pass filter. The filtered pair gives a piecewise phase error. Inside a ±45° cone the error is the ratio Q/I, and outside it is clipped to one full unit. A one-zero loop filter turns that error into a frequency increment. The frequency is held inside a programmable window, and each sample it is added to a phase accumulator.

The outputs are the filtered in-phase level, which a separate lock detector uses, the current phase, a strobe that marks each full-cycle wrap, and a double-frequency tone sin(2θ). Every coefficient, the nominal frequency and both frequency limits are plain inputs. A load strobe restarts the loop from the nominal frequency. The ratio is formed by a serial divider, so the block holds its ready output low while a division is running.

Top module: `pilot_pll`

## Requirements
- R1: After reset, out_phase, out_level, out_tone and out_wrap are all 0 and in_ready is 1.
- R2: Sine s and cosine c are taken from the phase before the update. With cfg_cplx=0 the mixer gives I=(s·in_re)>>>15 and Q=(c·in_re)>>>15, and in_im is ignored. With cfg_cplx=1 it gives I=(s·in_re−c·in_im)>>>15 and Q=(c·in_re+s·in_im)>>>15. Both results saturate to the signed 16-bit range.
- R3: The table holds T[k]=floor(32767·16·p/(5·64²−4·p)) with p=k·(64−k), for k=0..32. The table index is k=phase[13:9] and the quadrant is phase[15:14]. Quadrant 0 gives s=T[k], quadrant 1 gives s=T[32−k], quadrant 2 gives s=−T[k] and quadrant 3 gives s=−T[32−k]. The cosine is c(θ)=s(θ+0x4000).
- R4: Each channel computes y=sat16((pb0·x−pa1·y1−pa2·y2)>>>16), where y1 and y2 are that channel's last two outputs. out_level is the filtered I and is registered when a sample is accepted.
- R5: When the filtered I is greater than |Q|, the error is floor(|Q|·32768/I) and takes the sign of Q. Otherwise the error is +32768 when Q>0 and −32768 in every other case.
- R6: The frequency is updated as f += (lb0·e + lb1·e_prev)>>>16, and e_prev then becomes e.
- R7: After each update the frequency is clamped to the range cfg_fmin..cfg_fmax.
- R8: The phase advances by the new frequency modulo 2^16. out_wrap is 1 for exactly one cycle when that addition carries. The phase and the wrap strobe change only at this update.
- R9: out_tone = sat16((s·c)>>>14), using the phase before the update, and it is registered when the sample is accepted.
- R10: in_ready falls after an accepted sample. It returns 1 clock edge later when no division is needed and 17 edges later when a division is needed.
- R11: cfg_load presets the frequency to cfg_nom, clears the phase, both filter histories, the error and e_prev, drops out_wrap and aborts any sample in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_load | input | 1 | restart the loop from the nominal frequency |
| cfg_cplx | input | 1 | 1 = complex input, 0 = real input |
| cfg_nom | input | 16 | nominal frequency, in cycles/2^16 per sample |
| cfg_fmin | input | 16 | lower frequency limit |
| cfg_fmax | input | 16 | upper frequency limit |
| cfg_pb0 | input | 18 | filter numerator gain, Q2.16 |
| cfg_pa1 | input | 18 | filter first feedback coefficient, Q2.16 |
| cfg_pa2 | input | 18 | filter second feedback coefficient, Q2.16 |
| cfg_lb0 | input | 18 | loop gain on the present error, Q2.16 |
| cfg_lb1 | input | 18 | loop gain on the previous error, Q2.16 |
| in_valid | input | 1 | sample strobe |
| in_ready | output | 1 | block can accept a sample |
| in_re | input | 16 | real part of the sample, Q1.15 |
| in_im | input | 16 | imaginary part of the sample, Q1.15 |
| out_level | output | 16 | filtered in-phase level |
| out_tone | output | 16 | sin(2θ) tone |
| out_phase | output | 16 | phase accumulator |
| out_wrap | output | 1 | phase wrap strobe |

## Verification
A table of mixed real and complex samples runs with a mild loop gain and a narrow frequency window. It separates the two mixer equations and shows whether in_im is ignored. It also exercises every quadrant of the sine table. A complex sample at zero phase with unit loop gain exposes the divided ratio in the phase step and the long ready gap. A zero sample and a positive real sample drive the clipped errors of both signs into both clamp limits. A pure feedback filter setting accumulates samples, which shows whether each of the y1 and y2 terms is used and whether a load clears the history. Fixed-frequency runs near full scale tell a wrap from a non-wrap.

// File: rtl/pilot_pll_pkg.sv
package pilot_pll_pkg;
  localparam int DW = 16;
  localparam int CW = 18;
  localparam int CF = 16;
  localparam int PW = 16;
  localparam int QB = 5;
  localparam int QN = 1 << QB;
  localparam int FB = DW - 1;
  localparam int EW = DW + 2;
  localparam longint SMAX = (longint'(1) << FB) - 1;
  localparam longint SMIN = -(longint'(1) << FB);

  typedef logic signed [DW-1:0] smp_t;
  typedef logic signed [CW-1:0] coef_t;
  typedef logic [PW-1:0]        ph_t;
  typedef logic signed [EW-1:0] err_t;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_UPD} st_t;

  localparam err_t ERR_ONE = err_t'(longint'(1) << FB);

  function automatic smp_t sat_smp(input longint v);
    if (v > SMAX) return smp_t'(SMAX);
    if (v < SMIN) return smp_t'(SMIN);
    return smp_t'(v);
  endfunction

  // quarter-wave entry from a rational sine approximation
  function automatic smp_t qw_entry(input int k);
    longint d, p;
    d = 2 * QN;
    p = longint'(k) * (d - longint'(k));
    return smp_t'((SMAX * 16 * p) / (5 * d * d - 4 * p));
  endfunction

  // (a*b +/- c*d) >>> FB, saturated
  function automatic smp_t mix_term(input smp_t a, input smp_t b, input smp_t c,
                                    input smp_t d, input logic neg);
    longint t;
    t = longint'(c) * longint'(d);
    if (neg) t = -t;
    return sat_smp((longint'(a) * longint'(b) + t) >>> FB);
  endfunction

  function automatic smp_t tone_of(input smp_t s, input smp_t c);
    return sat_smp((longint'(s) * longint'(c)) >>> (FB - 1));
  endfunction
endpackage

// File: rtl/pilot_pll_sincos.sv
module pilot_pll_sincos
  import pilot_pll_pkg::*;
(
  input  ph_t  phase,
  output smp_t sin_o,
  output smp_t cos_o
);
  smp_t tab [QN+1];
  for (genvar g = 0; g <= QN; g++) begin : g_tab
    assign tab[g] = qw_entry(g);
  end

  logic [1:0]    quad;
  logic [QB-1:0] k;
  logic [QB:0]   ka, kb;
  smp_t          ta, tb;

  assign quad = phase[PW-1 -: 2];
  assign k    = phase[PW-3 -: QB];
  assign ka   = {1'b0, k};
  assign kb   = (QB+1)'(QN) - ka;
  assign ta   = tab[ka];
  assign tb   = tab[kb];

  always_comb begin
    case (quad)
      2'd0:    begin sin_o = ta;  cos_o = tb;  end
      2'd1:    begin sin_o = tb;  cos_o = -ta; end
      2'd2:    begin sin_o = -ta; cos_o = -tb; end
      default: begin sin_o = -tb; cos_o = ta;  end
    endcase
  end
endmodule

// File: rtl/pilot_pll_iir2.sv
module pilot_pll_iir2
  import pilot_pll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  smp_t  x,
  input  coef_t b0,
  input  coef_t a1,
  input  coef_t a2,
  output smp_t  y
);
  smp_t   y1, y2;
  longint acc;

  always_comb begin
    acc = (longint'(b0) * longint'(x) - longint'(a1) * longint'(y1)
           - longint'(a2) * longint'(y2)) >>> CF;
    y = sat_smp(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y1 <= '0;
      y2 <= '0;
    end else if (clr) begin
      y1 <= '0;
      y2 <= '0;
    end else if (en) begin
      y2 <= y1;
      y1 <= y;
    end
  end
endmodule

// File: rtl/pilot_pll_div.sv
module pilot_pll_div
  import pilot_pll_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [FB-1:0] quo,
  output logic          done
);
  localparam int CNTW = $clog2(FB + 1);

  logic [DW-1:0]   rem;
  logic [CNTW-1:0] cnt;
  logic [DW:0]     trial, diff;
  logic            take;

  assign trial = {rem, 1'b0};
  assign diff  = trial - {1'b0, den};
  assign take  = trial >= {1'b0, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; quo <= '0; cnt <= '0; done <= 1'b0;
    end else if (clr) begin
      cnt <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= num;
        quo <= '0;
        cnt <= CNTW'(FB);
      end else if (cnt != '0) begin
        rem <= take ? diff[DW-1:0] : trial[DW-1:0];
        quo <= {quo[FB-2:0], take};
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pilot_pll.sv
module pilot_pll
  import pilot_pll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_load,
  input  logic  cfg_cplx,
  input  ph_t   cfg_nom,
  input  ph_t   cfg_fmin,
  input  ph_t   cfg_fmax,
  input  coef_t cfg_pb0,
  input  coef_t cfg_pa1,
  input  coef_t cfg_pa2,
  input  coef_t cfg_lb0,
  input  coef_t cfg_lb1,
  input  logic  in_valid,
  output logic  in_ready,
  input  smp_t  in_re,
  input  smp_t  in_im,
  output smp_t  out_level,
  output smp_t  out_tone,
  output ph_t   out_phase,
  output logic  out_wrap
);
  st_t           state;
  ph_t           phase_q, freq_q, freq_nxt;
  err_t          err_q, errp_q;
  smp_t          s_w, c_w, im_w;
  smp_t          mix  [2];
  smp_t          filt [2];
  logic          accept, upd_ev, need_div, div_done, q_neg;
  logic [FB-1:0] div_q;
  logic [DW-1:0] abs_q;
  logic [PW:0]   ph_sum;
  longint        fsum;

  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid && in_ready && !cfg_load;
  assign upd_ev    = (state == ST_UPD) && !cfg_load;
  assign out_phase = phase_q;

  pilot_pll_sincos u_sc (.phase(phase_q), .sin_o(s_w), .cos_o(c_w));

  assign im_w   = cfg_cplx ? in_im : '0;
  assign mix[0] = mix_term(s_w, in_re, c_w, im_w, 1'b1);
  assign mix[1] = mix_term(c_w, in_re, s_w, im_w, 1'b0);

  for (genvar ch = 0; ch < 2; ch++) begin : g_lpf
    pilot_pll_iir2 u_lpf (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .en(accept),
      .x(mix[ch]), .b0(cfg_pb0), .a1(cfg_pa1), .a2(cfg_pa2), .y(filt[ch])
    );
  end

  assign abs_q    = DW'(filt[1] < 0 ? -longint'(filt[1]) : longint'(filt[1]));
  assign need_div = longint'(filt[0]) > longint'(abs_q);

  pilot_pll_div u_div (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .start(accept && need_div),
    .num(abs_q), .den(DW'(filt[0])), .quo(div_q), .done(div_done)
  );

  always_comb begin
    fsum = longint'(freq_q) + ((longint'(cfg_lb0) * longint'(err_q)
            + longint'(cfg_lb1) * longint'(errp_q)) >>> CF);
    if (fsum < longint'(cfg_fmin))      freq_nxt = cfg_fmin;
    else if (fsum > longint'(cfg_fmax)) freq_nxt = cfg_fmax;
    else                                freq_nxt = ph_t'(fsum);
  end
  assign ph_sum = {1'b0, phase_q} + {1'b0, freq_nxt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; phase_q <= '0; freq_q <= '0; err_q <= '0; errp_q <= '0;
      out_level <= '0; out_tone <= '0; out_wrap <= 1'b0; q_neg <= 1'b0;
    end else if (cfg_load) begin
      state <= ST_IDLE; phase_q <= '0; freq_q <= cfg_nom; err_q <= '0; errp_q <= '0;
      out_wrap <= 1'b0;
    end else begin
      out_wrap <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          out_level <= filt[0];
          out_tone  <= tone_of(s_w, c_w);
          q_neg     <= filt[1] < 0;
          if (need_div) state <= ST_DIV;
          else begin
            err_q <= (filt[1] > 0) ? ERR_ONE : -ERR_ONE;
            state <= ST_UPD;
          end
        end
        ST_DIV: if (div_done) begin
          err_q <= q_neg ? -err_t'(div_q) : err_t'(div_q);
          state <= ST_UPD;
        end
        default: begin
          freq_q   <= freq_nxt;
          errp_q   <= err_q;
          phase_q  <= ph_sum[PW-1:0];
          out_wrap <= ph_sum[PW];
          state    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pilot_pll_chk.sv
module pilot_pll_chk
  import pilot_pll_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cfg_load,
  input ph_t  cfg_nom,
  input ph_t  cfg_fmin,
  input ph_t  cfg_fmax,
  input logic in_ready,
  input ph_t  out_phase,
  input logic out_wrap,
  input logic accept,
  input logic upd_ev,
  input ph_t  freq_q,
  input err_t err_q
);
  a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  a_r7_freq_window: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ev && cfg_fmin <= cfg_fmax) |=>
      (freq_q >= $past(cfg_fmin) && freq_q <= $past(cfg_fmax)));

  a_r8_wrap_back: assert property (@(posedge clk) disable iff (!rst_n)
    out_wrap |-> (out_phase < $past(out_phase)));

  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_ev) && !$past(cfg_load)) |-> $stable(out_phase));

  a_r11_load_preset: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (out_phase == '0 && freq_q == $past(cfg_nom) && !out_wrap));

  a_r5_err_range: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ev |-> (err_q <= ERR_ONE && err_q >= -ERR_ONE));
endmodule

bind pilot_pll pilot_pll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_nom(cfg_nom),
  .cfg_fmin(cfg_fmin), .cfg_fmax(cfg_fmax), .in_ready(in_ready),
  .out_phase(out_phase), .out_wrap(out_wrap), .accept(accept),
  .upd_ev(upd_ev), .freq_q(freq_q), .err_q(err_q)
);

// File: tb/pilot_pll_test.sv
`timescale 1ns/1ps
module pilot_pll_test;
  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, cfg_cplx = 1'b0, in_valid = 1'b0;
  logic [15:0] cfg_nom = '0, cfg_fmin = '0, cfg_fmax = '0;
  logic signed [17:0] pb0 = '0, pa1 = '0, pa2 = '0, lb0 = '0, lb1 = '0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic in_ready, out_wrap;
  logic signed [15:0] out_level, out_tone;
  logic [15:0] out_phase;

  pilot_pll uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cplx(cfg_cplx),
    .cfg_nom(cfg_nom), .cfg_fmin(cfg_fmin), .cfg_fmax(cfg_fmax),
    .cfg_pb0(pb0), .cfg_pa1(pa1), .cfg_pa2(pa2), .cfg_lb0(lb0), .cfg_lb1(lb1),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_level(out_level), .out_tone(out_tone), .out_phase(out_phase), .out_wrap(out_wrap)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  // stimulus table: complex flag, real part, imaginary part
  localparam int NV = 12;
  localparam bit VCX [NV] = '{0, 0, 0, 1, 1, 1, 0, 1, 0, 1, 1, 0};
  localparam int VRE [NV] = '{20000, -20000, 32767, 12000, -30000, 5000,
                              -32768, 32767, 1000, -1, 0, 15000};
  localparam int VIM [NV] = '{9999, 0, -5000, 8000, -12000, -32768,
                              32767, 32767, 0, 20000, -25000, -15000};

  // bench reference state
  longint m_ph, m_fr, m_ep, hi1, hi2, hq1, hq2;
  longint e_level, e_tone, e_phase, e_wrap, e_lat;

  function automatic longint sat16(input longint v);
    return v > 32767 ? 32767 : (v < -32768 ? -32768 : v);
  endfunction

  function automatic longint tab(input longint k);
    longint p;
    p = k * (64 - k);
    return (32767 * 16 * p) / (5 * 64 * 64 - 4 * p);
  endfunction

  function automatic longint bsin(input longint ph);
    longint q, k;
    q = (ph >> 14) & 3;
    k = (ph >> 9) & 31;
    if (q == 0) return tab(k);
    if (q == 1) return tab(32 - k);
    if (q == 2) return -tab(k);
    return -tab(32 - k);
  endfunction

  function automatic longint bcos(input longint ph);
    return bsin((ph + 16384) & 16'hFFFF);
  endfunction

  task automatic model_step(input bit cx, input longint re, input longint im);
    longint s, c, x_i, x_q, yi, yq, aq, e, f;
    s = bsin(m_ph); c = bcos(m_ph);
    if (!cx) im = 0;
    x_i = sat16((s * re - c * im) >>> 15);
    x_q = sat16((c * re + s * im) >>> 15);
    yi = sat16((longint'(pb0) * x_i - longint'(pa1) * hi1 - longint'(pa2) * hi2) >>> 16);
    yq = sat16((longint'(pb0) * x_q - longint'(pa1) * hq1 - longint'(pa2) * hq2) >>> 16);
    hi2 = hi1; hi1 = yi; hq2 = hq1; hq1 = yq;
    e_level = yi;
    e_tone = sat16((s * c) >>> 14);
    aq = yq < 0 ? -yq : yq;
    if (yi > aq) begin
      e = (aq * 32768) / yi;
      if (yq < 0) e = -e;
      e_lat = 17;
    end else begin
      e = yq > 0 ? 32768 : -32768;
      e_lat = 1;
    end
    f = m_fr + ((longint'(lb0) * e + longint'(lb1) * m_ep) >>> 16);
    if (f < longint'(cfg_fmin)) f = longint'(cfg_fmin);
    if (f > longint'(cfg_fmax)) f = longint'(cfg_fmax);
    m_fr = f; m_ep = e;
    e_wrap = (m_ph + f) >= 65536 ? 1 : 0;
    m_ph = (m_ph + f) & 16'hFFFF;
    e_phase = m_ph;
  endtask

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input string tag, input bit cx, input longint re, input longint im);
    int n;
    model_step(cx, re, im);
    @(negedge clk);
    cfg_cplx = cx; in_re = 16'(re); in_im = 16'(im); in_valid = 1'b1;
    @(posedge clk); #5;
    in_valid = 1'b0;
    n = 0;
    while (!in_ready) begin @(posedge clk); #5; n++; end
    chk(tag, "level", longint'(out_level), e_level);
    chk(tag, "phase", longint'(out_phase), e_phase);
    chk("R9/R3", "tone", longint'(out_tone), e_tone);
    chk("R8", "wrap", longint'(out_wrap), e_wrap);
    chk("R10", "ready gap", longint'(n), e_lat);
  endtask

  task automatic load(input longint nom, input longint fmin, input longint fmax);
    @(negedge clk);
    cfg_nom = 16'(nom); cfg_fmin = 16'(fmin); cfg_fmax = 16'(fmax); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_ph = 0; m_fr = nom; m_ep = 0; hi1 = 0; hi2 = 0; hq1 = 0; hq2 = 0;
    chk("R11", "phase after load", longint'(out_phase), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "phase", longint'(out_phase), 0);
    chk("R1", "level", longint'(out_level), 0);
    chk("R1", "tone", longint'(out_tone), 0);
    chk("R1", "wrap", longint'(out_wrap), 0);
    chk("R1", "ready", longint'(in_ready), 1);

    // R2 mixer, R3 table, R4 level over the stimulus table
    pb0 = 18'sd65536; pa1 = '0; pa2 = '0; lb0 = 18'sd4096; lb1 = -18'sd2048;
    load(16'h0C00, 16'h0400, 16'h1400);
    for (int v = 0; v < NV; v++) send("R2/R4", VCX[v], VRE[v], VIM[v]);

    // R5 divided ratio, both signs, with unit loop gain
    lb0 = 18'sd65536; lb1 = '0;
    load(0, 0, 16'hFFFF);
    send("R5", 1'b1, 8192, -16384);
    send("R5", 1'b1, -8192, -16384);
    send("R5", 1'b1, 3000, 30000);

    // R7 clamp low with zero input, clamp high with positive Q
    load(16'h2000, 16'h1F9C, 16'h2064);
    send("R7", 1'b0, 0, 0);
    load(16'h2000, 16'h1F9C, 16'h2064);
    send("R7", 1'b0, 10000, 0);

    // R6 loop filter zero: previous error only
    lb0 = '0; lb1 = 18'sd65536;
    load(16'h9000, 0, 16'hFFFF);
    send("R6", 1'b0, 0, 0);
    send("R6", 1'b0, 0, 0);
    send("R6", 1'b0, 0, 0);

    // R4 history: y = x + y1, then y = x + y2
    lb0 = '0; lb1 = '0; pb0 = 18'sd65536; pa1 = -18'sd65536; pa2 = '0;
    load(0, 0, 0);
    send("R4", 1'b1, 0, -1000);
    send("R4", 1'b1, 0, -1000);
    send("R4", 1'b1, 0, -1000);
    pa1 = '0; pa2 = -18'sd65536;
    send("R4", 1'b1, 0, -500);
    send("R4", 1'b1, 0, -500);
    // R11 load clears the history
    load(16'h0100, 16'h0100, 16'h0100);
    send("R11", 1'b1, 0, -700);

    // R8 wraps at a fixed high frequency, then the strobe drops
    pa2 = '0;
    load(16'hF000, 16'hF000, 16'hF000);
    send("R8", 1'b0, 4000, 0);
    send("R8", 1'b0, 4000, 0);
    send("R8", 1'b1, 4000, 4000);
    @(posedge clk); #5;
    chk("R8", "wrap one cycle", longint'(out_wrap), 0);

    // R9 tone near 45 degrees
    load(16'h2000, 16'h2000, 16'h2000);
    send("R9", 1'b0, 100, 0);
    send("R9", 1'b0, 100, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule